// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This block is a memory-mapped real-time clock for an always-on power domain. A 47-bit counter advances on every rising edge of a slow low-power clock, nominally 32768 Hz. The low 15 bits count fractions of a second, and the upper 32 bits count whole seconds. Software reads the counter as two 32-bit words. It can preload the counter while counting is stopped. It also programs a 32-bit seconds alarm. When the seconds field reaches the alarm value, a sticky status flag is set, and an interrupt/wakeup line can be raised from it.

The bus side and the slow side run on unrelated clocks. Control bits are passed into the slow domain and back again before they read back, so software learns that a change has taken effect by polling the control word. Counter values cross into the bus domain through a toggle handshake. Each register word is therefore coherent on its own, but a pair of reads that straddles a tick can disagree, and software re-reads until two reads match. A guard word must hold a fixed key before the block reports itself valid.

Top module: `lp_rtc_top`

## Requirements
- R1: After reset these all read 0: control readback, status, both counter words, alarm and guard. `irq_o` and `valid_o` are low.
- R2: The control word is at byte offset 0x04, with bit 0 = count enable, bit 1 = alarm enable and bit 3 = wakeup-interrupt enable. Other bits read 0. A written value reads back only after it has crossed into the slow domain and back, never on the cycle after the write.
- R3: While the effective count enable is set, the counter advances by one per slow-clock edge. While it is clear, the counter holds. Offset 0x1C returns counter bits 46:32 in bits 14:0. Offset 0x20 returns bits 31:0.
- R4: While the count enable reads back 0, a write to 0x20 loads counter bits 31:0 and a write to 0x1C loads bits 46:32. The new value is visible in readback once it has passed through the slow domain.
- R5: Writes to 0x20 or 0x1C while the count enable reads back 1 are ignored.
- R6: The counter wraps from all ones to zero.
- R7: The seconds value is counter bits 46:32..15, i.e. counter[46:15]. The alarm word is at 0x24. Status bit 0 at 0x18 is set when the seconds value becomes equal to the alarm while the alarm enable is in effect. Without a match, or with the alarm enable off, it stays clear.
- R8: Status bit 0 is sticky. Writing 1 to bit 0 clears it, so writing 0xFFFFFFFF clears it too. Writing 0 has no effect. A set in the same cycle as a clear wins.
- R9: `irq_o` is high exactly while status bit 0, the effective alarm enable and the effective wakeup enable are all set. It stays high until the status is cleared.
- R10: The guard word at 0x30 reads back what was written. `valid_o` is high only while it holds 0x41736166.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | Low-power counting clock, asynchronous to clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high together with req_i |
| addr_i | input | 6 | Byte offset within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Alarm interrupt / wakeup request |
| valid_o | output | 1 | Guard word holds the key |

## Verification
The assertions assume that the slow clock period is at least four bus clock periods. This keeps a captured counter word stable from the tick that produced it until the capture. They also assume that a load value stays unchanged until its toggle has crossed into the slow domain. The stimulus runs the slow clock at nine bus periods with edges offset from the bus edges. It writes the counter only after polling the count enable back to 0, and it waits dozens of bus cycles between a load and the next access to the same word. Alarm cases preload the counter a few ticks before the target second, so every match falls inside a short, bounded wait.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int unsigned CNT_W  = 47;
  localparam int unsigned SUB_W  = 15;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 6;
  localparam int unsigned CTL_W  = 3;

  // byte offsets seen by software
  localparam int unsigned OFS_CTRL   = 'h04;
  localparam int unsigned OFS_STAT   = 'h18;
  localparam int unsigned OFS_CNT_HI = 'h1C;
  localparam int unsigned OFS_CNT_LO = 'h20;
  localparam int unsigned OFS_ALARM  = 'h24;
  localparam int unsigned OFS_GUARD  = 'h30;

  // control word bit positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_ALM  = 1;
  localparam int unsigned CB_WAKE = 3;
  localparam int unsigned SB_ALM  = 0;

  // packed internal control vector indices
  localparam int unsigned CI_RUN  = 0;
  localparam int unsigned CI_ALM  = 1;
  localparam int unsigned CI_WAKE = 2;

  localparam logic [31:0] GUARD_KEY = 32'h4173_6166;
endpackage

// File: rtl/lp_rtc_sync.sv
module lp_rtc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lp_rtc_slow.sv
module lp_rtc_slow
  import lp_rtc_pkg::*;
#(
  parameter int unsigned CNT_BITS    = CNT_W,
  parameter int unsigned DATA_BITS   = DW,
  parameter int unsigned CTL_BITS    = CTL_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          slow_clk_i,
  input  logic                          rst_ni,
  input  logic [CTL_BITS-1:0]           ctl_i,
  input  logic                          lo_tgl_i,
  input  logic                          hi_tgl_i,
  input  logic [DATA_BITS-1:0]          lo_i,
  input  logic [CNT_BITS-DATA_BITS-1:0] hi_i,
  output logic [CTL_BITS-1:0]           ctl_s_o,
  output logic [CNT_BITS-1:0]           cnt_o,
  output logic                          upd_tgl_o
);
  logic [CTL_BITS-1:0] ctl_s;
  logic lo_tgl_s, hi_tgl_s, lo_prev_q, hi_prev_q;
  logic [CNT_BITS-1:0] cnt_q;
  logic upd_q;

  lp_rtc_sync #(.W(CTL_BITS + 2), .STAGES(SYNC_STAGES)) u_sync_in (
    .clk_i (slow_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hi_tgl_i, lo_tgl_i, ctl_i}),
    .q_o   ({hi_tgl_s, lo_tgl_s, ctl_s})
  );

  logic ld_lo, ld_hi, run_s;
  assign ld_lo = lo_tgl_s ^ lo_prev_q;
  assign ld_hi = hi_tgl_s ^ hi_prev_q;
  assign run_s = ctl_s[CI_RUN];

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      upd_q     <= 1'b0;
      lo_prev_q <= 1'b0;
      hi_prev_q <= 1'b0;
    end else begin
      lo_prev_q <= lo_tgl_s;
      hi_prev_q <= hi_tgl_s;
      if (ld_lo || ld_hi) begin
        if (ld_lo) cnt_q[DATA_BITS-1:0]        <= lo_i;
        if (ld_hi) cnt_q[CNT_BITS-1:DATA_BITS] <= hi_i;
        upd_q <= ~upd_q;
      end else if (run_s) begin
        cnt_q <= cnt_q + CNT_BITS'(1);
        upd_q <= ~upd_q;
      end
    end
  end

  assign ctl_s_o   = ctl_s;
  assign cnt_o     = cnt_q;
  assign upd_tgl_o = upd_q;

  // R3: stopped counter holds its value
  assert_hold_R3: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (!run_s && !ld_lo && !ld_hi) |=> $stable(cnt_q));
  // R6: running counter steps by one modulo 2^CNT_BITS
  assert_step_wrap_R6: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (run_s && !ld_lo && !ld_hi) |=> (cnt_q == $past(cnt_q) + CNT_BITS'(1)));
  // every counter change is announced to the bus side
  assert_announce_R3: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> !$stable(upd_q));
endmodule

// File: rtl/lp_rtc_cap.sv
module lp_rtc_cap
  import lp_rtc_pkg::*;
#(
  parameter int unsigned CNT_BITS    = CNT_W,
  parameter int unsigned CTL_BITS    = CTL_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_BITS-1:0] cnt_s_i,
  input  logic                upd_tgl_i,
  input  logic [CTL_BITS-1:0] ctl_s_i,
  output logic [CNT_BITS-1:0] cnt_o,
  output logic [CTL_BITS-1:0] ctl_rb_o
);
  logic upd_s, upd_prev_q, take;
  logic [CNT_BITS-1:0] cnt_q;

  lp_rtc_sync #(.W(CTL_BITS + 1), .STAGES(SYNC_STAGES)) u_sync_back (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({upd_tgl_i, ctl_s_i}),
    .q_o   ({upd_s, ctl_rb_o})
  );

  assign take = upd_s ^ upd_prev_q;

  // slow value is quiet for a whole slow period after each toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_prev_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      upd_prev_q <= upd_s;
      if (take) cnt_q <= cnt_s_i;
    end
  end

  assign cnt_o = cnt_q;

  assert_cap_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(cnt_q));
endmodule

// File: rtl/lp_rtc_regs.sv
module lp_rtc_regs
  import lp_rtc_pkg::*;
#(
  parameter int unsigned CNT_BITS  = CNT_W,
  parameter int unsigned SUB_BITS  = SUB_W,
  parameter int unsigned DATA_BITS = DW,
  parameter int unsigned ADDR_BITS = AW,
  parameter int unsigned CTL_BITS  = CTL_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_BITS-1:0]          addr_i,
  input  logic [DATA_BITS-1:0]          wdata_i,
  output logic [DATA_BITS-1:0]          rdata_o,
  input  logic [CTL_BITS-1:0]           ctl_rb_i,
  input  logic [CNT_BITS-1:0]           cnt_i,
  output logic [CTL_BITS-1:0]           ctl_o,
  output logic                          lo_tgl_o,
  output logic                          hi_tgl_o,
  output logic [DATA_BITS-1:0]          lo_o,
  output logic [CNT_BITS-DATA_BITS-1:0] hi_o,
  output logic                          irq_o,
  output logic                          valid_o
);
  localparam int unsigned HI_BITS  = CNT_BITS - DATA_BITS;
  localparam int unsigned SEC_BITS = CNT_BITS - SUB_BITS;

  logic [CTL_BITS-1:0]  ctl_q;
  logic [DATA_BITS-1:0] lo_q, guard_q;
  logic [HI_BITS-1:0]   hi_q;
  logic [SEC_BITS-1:0]  alarm_q;
  logic lo_tgl_q, hi_tgl_q, status_q, hit_q;

  logic wr, wr_ctrl, wr_stat, wr_lo, wr_hi, wr_alarm, wr_guard;
  assign wr       = req_i && we_i;
  assign wr_ctrl  = wr && (addr_i == ADDR_BITS'(OFS_CTRL));
  assign wr_stat  = wr && (addr_i == ADDR_BITS'(OFS_STAT));
  assign wr_lo    = wr && (addr_i == ADDR_BITS'(OFS_CNT_LO));
  assign wr_hi    = wr && (addr_i == ADDR_BITS'(OFS_CNT_HI));
  assign wr_alarm = wr && (addr_i == ADDR_BITS'(OFS_ALARM));
  assign wr_guard = wr && (addr_i == ADDR_BITS'(OFS_GUARD));

  logic run_rb, alm_rb, wake_rb;
  assign run_rb  = ctl_rb_i[CI_RUN];
  assign alm_rb  = ctl_rb_i[CI_ALM];
  assign wake_rb = ctl_rb_i[CI_WAKE];

  logic [SEC_BITS-1:0] sec;
  logic hit, hit_rise, stat_clr;
  assign sec      = cnt_i[CNT_BITS-1:SUB_BITS];
  assign hit      = (sec == alarm_q) && alm_rb;
  assign hit_rise = hit && !hit_q;
  assign stat_clr = wr_stat && wdata_i[SB_ALM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      lo_tgl_q <= 1'b0;
      hi_tgl_q <= 1'b0;
      alarm_q  <= '0;
      guard_q  <= '0;
      status_q <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      hit_q <= hit;
      if (wr_ctrl) begin
        ctl_q[CI_RUN]  <= wdata_i[CB_RUN];
        ctl_q[CI_ALM]  <= wdata_i[CB_ALM];
        ctl_q[CI_WAKE] <= wdata_i[CB_WAKE];
      end
      // counter loads only while counting is known to be stopped
      if (wr_lo && !run_rb) begin
        lo_q     <= wdata_i;
        lo_tgl_q <= ~lo_tgl_q;
      end
      if (wr_hi && !run_rb) begin
        hi_q     <= wdata_i[HI_BITS-1:0];
        hi_tgl_q <= ~hi_tgl_q;
      end
      if (wr_alarm) alarm_q <= wdata_i[SEC_BITS-1:0];
      if (wr_guard) guard_q <= wdata_i;
      if (hit_rise)      status_q <= 1'b1;
      else if (stat_clr) status_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_BITS'(OFS_CTRL): begin
        rdata_o[CB_RUN]  = run_rb;
        rdata_o[CB_ALM]  = alm_rb;
        rdata_o[CB_WAKE] = wake_rb;
      end
      ADDR_BITS'(OFS_STAT):   rdata_o[SB_ALM] = status_q;
      ADDR_BITS'(OFS_CNT_HI): rdata_o = DATA_BITS'(cnt_i[CNT_BITS-1:DATA_BITS]);
      ADDR_BITS'(OFS_CNT_LO): rdata_o = cnt_i[DATA_BITS-1:0];
      ADDR_BITS'(OFS_ALARM):  rdata_o = DATA_BITS'(alarm_q);
      ADDR_BITS'(OFS_GUARD):  rdata_o = guard_q;
      default:                rdata_o = '0;
    endcase
  end

  assign ctl_o    = ctl_q;
  assign lo_tgl_o = lo_tgl_q;
  assign hi_tgl_o = hi_tgl_q;
  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign irq_o    = status_q && alm_rb && wake_rb;
  assign valid_o  = (guard_q == GUARD_KEY);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !stat_clr) |=> status_q);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr && !hit_rise) |=> !status_q);
  assert_set_on_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past((sec == alarm_q) && alm_rb));
  assert_load_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_lo || wr_hi) && run_rb) |=> ($stable(lo_tgl_q) && $stable(hi_tgl_q)));
endmodule

// File: rtl/lp_rtc_top.sv
module lp_rtc_top
  import lp_rtc_pkg::*;
#(
  parameter int unsigned CNT_BITS    = CNT_W,
  parameter int unsigned SUB_BITS    = SUB_W,
  parameter int unsigned DATA_BITS   = DW,
  parameter int unsigned ADDR_BITS   = AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 slow_clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [DATA_BITS-1:0] wdata_i,
  output logic [DATA_BITS-1:0] rdata_o,
  output logic                 irq_o,
  output logic                 valid_o
);
  localparam int unsigned HI_BITS = CNT_BITS - DATA_BITS;

  logic [CTL_W-1:0]     ctl_q, ctl_s, ctl_rb;
  logic [CNT_BITS-1:0]  cnt_s, cnt_b;
  logic                 upd_tgl, lo_tgl, hi_tgl;
  logic [DATA_BITS-1:0] lo_val;
  logic [HI_BITS-1:0]   hi_val;

  lp_rtc_regs #(
    .CNT_BITS(CNT_BITS), .SUB_BITS(SUB_BITS), .DATA_BITS(DATA_BITS),
    .ADDR_BITS(ADDR_BITS), .CTL_BITS(CTL_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctl_rb_i(ctl_rb),
    .cnt_i   (cnt_b),
    .ctl_o   (ctl_q),
    .lo_tgl_o(lo_tgl),
    .hi_tgl_o(hi_tgl),
    .lo_o    (lo_val),
    .hi_o    (hi_val),
    .irq_o   (irq_o),
    .valid_o (valid_o)
  );

  lp_rtc_slow #(
    .CNT_BITS(CNT_BITS), .DATA_BITS(DATA_BITS), .CTL_BITS(CTL_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_slow (
    .slow_clk_i(slow_clk_i),
    .rst_ni    (rst_ni),
    .ctl_i     (ctl_q),
    .lo_tgl_i  (lo_tgl),
    .hi_tgl_i  (hi_tgl),
    .lo_i      (lo_val),
    .hi_i      (hi_val),
    .ctl_s_o   (ctl_s),
    .cnt_o     (cnt_s),
    .upd_tgl_o (upd_tgl)
  );

  lp_rtc_cap #(
    .CNT_BITS(CNT_BITS), .CTL_BITS(CTL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_s_i  (cnt_s),
    .upd_tgl_i(upd_tgl),
    .ctl_s_i  (ctl_s),
    .cnt_o    (cnt_b),
    .ctl_rb_o (ctl_rb)
  );
endmodule

// File: tb/lp_rtc_top_tb_top.sv
module lp_rtc_top_tb_top;
  localparam logic [5:0] A_CTRL = 6'h04, A_STAT = 6'h18, A_HI = 6'h1C,
                         A_LO = 6'h20, A_ALARM = 6'h24, A_GUARD = 6'h30;

  typedef struct packed {
    logic [46:0] load;
    logic [31:0] alarm;
    logic [3:0]  ctl;
    logic        fire;
    logic [14:0] hi;
  } vec_t;

  // load, alarm, control, expect status, expected high word after the wait
  localparam vec_t VEC [6] = '{
    '{47'h0000_0002_7FF8, 32'd5,          4'hB, 1'b1, 15'h000},
    '{47'h0000_0002_8008, 32'd4,          4'hB, 1'b0, 15'h000},
    '{47'h7FFF_FFFF_FFF8, 32'd0,          4'hB, 1'b1, 15'h000},
    '{47'h0000_0002_7FF8, 32'd5,          4'h9, 1'b0, 15'h000},
    '{47'h091A_2B3B_FFFA, 32'h1234_5679,  4'hB, 1'b0, 15'h091A},
    '{47'h091A_2B3B_FFFA, 32'h1234_5678,  4'hB, 1'b1, 15'h091A}
  };

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, valid;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  initial begin
    #2;
    forever #45 slow_clk = ~slow_clk;
  end

  lp_rtc_top dut_i (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .valid_o(valid)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_ctl(input logic [31:0] exp, input string tag);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 300; i++) begin
      rd(A_CTRL, v);
      if (v == exp) break;
    end
    chk(tag, v, exp);
  endtask

  initial begin
    logic [31:0] v, a, b;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_HI, v);    chk("R1 cnt hi", v, 0);
    rd(A_LO, v);    chk("R1 cnt lo", v, 0);
    rd(A_ALARM, v); chk("R1 alarm", v, 0);
    rd(A_GUARD, v); chk("R1 guard", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 valid", valid, 0);

    // R10 guard word
    wr(A_GUARD, 32'h4173_6167);
    rd(A_GUARD, v); chk("R10 guard readback", v, 32'h4173_6167);
    chk("R10 valid wrong key", valid, 0);
    wr(A_GUARD, 32'h4173_6166);
    chk("R10 valid key", valid, 1);

    // R2 delayed readback, reserved bit 2 reads 0
    wr(A_CTRL, 32'hF);
    rd(A_CTRL, v); chk("R2 ctrl not yet effective", v, 0);
    wait_ctl(32'hB, "R2 ctrl readback");

    // table of alarm scenarios (R4 R6 R7)
    for (int k = 0; k < 6; k++) begin
      wr(A_CTRL, 32'h0);
      wait_ctl(32'h0, "R2 stop");
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, v); chk("R8 clear all", v, 0);
      wr(A_LO, VEC[k].load[31:0]);
      wr(A_HI, {17'b0, VEC[k].load[46:32]});
      idle(60);
      rd(A_LO, v); chk("R4 load lo", v, VEC[k].load[31:0]);
      rd(A_HI, v); chk("R4 load hi", v, {17'b0, VEC[k].load[46:32]});
      wr(A_ALARM, VEC[k].alarm);
      wr(A_CTRL, {28'b0, VEC[k].ctl});
      wait_ctl({28'b0, VEC[k].ctl}, "R2 run");
      idle(400);
      rd(A_STAT, v); chk($sformatf("R7 status vec%0d", k), v, {31'b0, VEC[k].fire});
      chk($sformatf("R9 irq vec%0d", k), irq, VEC[k].fire && VEC[k].ctl[1] && VEC[k].ctl[3]);
      rd(A_HI, v); chk($sformatf("R6 hi word vec%0d", k), v, {17'b0, VEC[k].hi});
    end

    // R9 gating by wakeup enable
    wr(A_CTRL, 32'h3);
    wait_ctl(32'h3, "R2 no wake");
    chk("R9 irq masked", irq, 0);
    rd(A_STAT, v); chk("R8 status kept", v, 1);
    wr(A_CTRL, 32'hB);
    wait_ctl(32'hB, "R2 wake");
    chk("R9 irq back", irq, 1);

    // R8 write 0 no effect, write 1 clears
    wr(A_STAT, 32'h0);
    idle(2);
    rd(A_STAT, v); chk("R8 write zero", v, 1);
    chk("R9 irq held", irq, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R8 write one", v, 0);
    chk("R9 irq cleared", irq, 0);

    // R5 loads ignored while running
    wr(A_LO, 32'h0);
    wr(A_HI, 32'h0);
    idle(60);
    rd(A_HI, v); chk("R5 hi unchanged", v, 32'h091A);

    // R3 running rate: 3600 ns = 40 slow periods
    rd(A_LO, a);
    idle(359);
    rd(A_LO, b);
    chk("R3 step count", ((b - a) >= 39) && ((b - a) <= 41), 1);

    // R3 hold when stopped
    wr(A_CTRL, 32'h0);
    wait_ctl(32'h0, "R2 stop final");
    idle(20);
    rd(A_LO, a);
    idle(200);
    rd(A_LO, b);
    chk("R3 frozen", b, a);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule